// File: doc/BRIEF.md
# Microcoded Control-Word Sequencer

This block is the control unit of a small 16-bit register CPU. It receives the opcode field of the fetched instruction word and the ALU zero flag. It walks each instruction through a short series of timing states, and in every state it emits a 28-bit control word. Each bit of that word enables exactly one bus driver, register load or datapath operation. Two side strobes, instruction-register load and program-counter step, sit outside the word and are raised only in the fetch state. The datapath, memories and ALU are outside this block.

The state machine has five states, with the debug encoding shown:

- `ST_FETCH` (0) always moves to `ST_DECODE` (1).
- `ST_DECODE` always moves to `ST_EXEC1` (2).
- From `ST_EXEC1`, a word carrying the stop bit leads to `ST_HALT` (4). A word carrying the end bit leads back to `ST_FETCH`. Any other word leads to `ST_EXEC2` (3).
- `ST_EXEC2` always returns to `ST_FETCH`.
- `ST_HALT` holds until reset.

The opcode is captured at the end of the fetch state. During the execute states, a combinational table indexed by that opcode and by the execute step produces the word.

Top module: `ctrl_seq`

Control word bit positions used below:

| Bit | Signal |
|---|---|
| 0 | end of instruction |
| 1 | idle |
| 2 | stop |
| 3 | memory read drive |
| 4 | register write |
| 5 | immediate drive |
| 6 | output port load |
| 7 | memory write |
| 8 | register A drive |
| 9 | address drive |
| 10 | destination select |
| 11 | branch |
| 12 | flag load |
| 13 | ALU drive |
| 14 | register copy |
| 15 | branch-if-zero |
| 16 | source from immediate field |
| 17 | cross bus |
| 18 | register B enable |
| 19 | register B to ALU |
| 20 | register A to ALU |
| 21 | remainder select |
| 22 | address register load |
| 23 | register B drive |
| 24 | immediate register load |
| 25 | program word drive |
| 26 | PC step |
| 27 | second cross bus (never asserted) |

## Requirements
- R1: While reset is held, and in the first cycle after it, the state is ST_FETCH (tstate_o = 0), ctrl_o is 0, and ir_load_o and pc_inc_o are 1.
- R2: Every instruction passes ST_FETCH (0), ST_DECODE (1) and ST_EXEC1 (2), one cycle each. Fetch raises ir_load_o and pc_inc_o with ctrl_o = 0. Decode drives all outputs to 0. The opcode is taken from opc_i at the end of the fetch cycle.
- R3: A state whose word has bit 0 set is followed by ST_FETCH. The word in ST_EXEC2 (3) always has bit 0 set.
- R4: Opcodes 2, 3, 4, 6 and 13 emit bits {26,25,22,17} (0x6420000) in ST_EXEC1.
- R5: In ST_EXEC2:
  - opcode 2 emits bits {10,9,4,3,0};
  - opcode 3 emits bits {9,6,3,0};
  - opcode 4 emits bits {10,9,8,7,0};
  - opcode 6 emits bits {11,9,0}.
- R6: Opcode 5 emits bits {26,25,24} in ST_EXEC1, then bits {10,5,4,0} in ST_EXEC2.
- R7: Opcodes 7 to 10 finish in ST_EXEC1 with bits {20,19,18,16,13,10,4,0}. Opcode 11 emits the same bits plus bit 21.
- R8: Opcode 12 finishes in ST_EXEC1 with bits {20,19,18,16,12,10,0}. It never asserts bit 4 or bit 13.
- R9: Opcode 13 emits bits {9,0} in ST_EXEC2, plus bit 15 when zero_i is 1, or plus bit 1 when zero_i is 0.
- R10: Opcodes 14 and 15 emit bits {23,22,18,17} in ST_EXEC1. In ST_EXEC2, opcode 14 emits bits {10,9,8,7,0} and opcode 15 emits bits {10,9,4,3,0}. Opcode 16 finishes in ST_EXEC1 with bits {23,18,16,14,10,4,0}.
- R11: Opcode 0 (reserved) and opcodes 17 to 63 finish in ST_EXEC1 with only bits {1,0}.
- R12: Opcode 1 emits only bit 2 in ST_EXEC1 and then enters ST_HALT (4). ST_HALT drives ctrl_o = bit 2 and ir_load_o = pc_inc_o = 0 until reset, whatever opc_i and zero_i do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opc_i | input | 6 | Opcode field (bits 15:10 of the fetched instruction) |
| zero_i | input | 1 | ALU zero flag |
| ctrl_o | output | 28 | Control word |
| tstate_o | output | 3 | Current timing state, for debug |
| ir_load_o | output | 1 | Instruction register load strobe |
| pc_inc_o | output | 1 | Program counter step strobe |

## Verification
The assertions assume that opc_i is stable and valid at the end of each fetch cycle. They also assume that zero_i is settled during the second execute step of a conditional jump, because the branch bit follows it combinationally. The stimulus changes opc_i and zero_i only just after a rising edge, at the start of each instruction. It changes them on purpose during the halt state, where both inputs must have no effect.

// File: rtl/ctrl_seq_pkg.sv
package ctrl_seq_pkg;

    localparam int CW_W = 28;

    // control word bit positions
    localparam int C_END        = 0;
    localparam int C_IDLE       = 1;
    localparam int C_STOP       = 2;
    localparam int C_MEM_RD     = 3;
    localparam int C_REG_WR     = 4;
    localparam int C_IMM_DRV    = 5;
    localparam int C_PORT_LD    = 6;
    localparam int C_MEM_WR     = 7;
    localparam int C_REGA_DRV   = 8;
    localparam int C_ADDR_DRV   = 9;
    localparam int C_DST_SEL    = 10;
    localparam int C_BRANCH     = 11;
    localparam int C_FLAG_LD    = 12;
    localparam int C_ALU_DRV    = 13;
    localparam int C_REG_COPY   = 14;
    localparam int C_BRANCH_Z   = 15;
    localparam int C_SRC_IMM    = 16;
    localparam int C_XBUS       = 17;
    localparam int C_REGB_EN    = 18;
    localparam int C_REGB_ALU   = 19;
    localparam int C_REGA_ALU   = 20;
    localparam int C_REM_SEL    = 21;
    localparam int C_ADDR_LD    = 22;
    localparam int C_REGB_DRV   = 23;
    localparam int C_IMM_LD     = 24;
    localparam int C_PROG_DRV   = 25;
    localparam int C_PC_STEP    = 26;
    localparam int C_XBUS2      = 27;

    typedef logic [CW_W-1:0] cword_t;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_EXEC1  = 3'd2,
        ST_EXEC2  = 3'd3,
        ST_HALT   = 3'd4
    } tstate_e;

    // opcode values
    localparam int OP_RSVD     = 0;
    localparam int OP_HALT     = 1;
    localparam int OP_LD_MEM   = 2;
    localparam int OP_PORT     = 3;
    localparam int OP_ST_MEM   = 4;
    localparam int OP_LD_IMM   = 5;
    localparam int OP_JUMP     = 6;
    localparam int OP_ADD      = 7;
    localparam int OP_SUB      = 8;
    localparam int OP_MUL      = 9;
    localparam int OP_DIV      = 10;
    localparam int OP_REM      = 11;
    localparam int OP_CMP      = 12;
    localparam int OP_JZ       = 13;
    localparam int OP_ST_IND   = 14;
    localparam int OP_LD_IND   = 15;
    localparam int OP_MOVE     = 16;

    function automatic cword_t cw_bit(input int n);
        cword_t w;
        w    = '0;
        w[n] = 1'b1;
        return w;
    endfunction

    // shared step patterns
    localparam cword_t K_WORD_TO_ADDR = cw_bit(C_PC_STEP) | cw_bit(C_PROG_DRV)
                                      | cw_bit(C_ADDR_LD) | cw_bit(C_XBUS);
    localparam cword_t K_WORD_TO_IMM  = cw_bit(C_PC_STEP) | cw_bit(C_PROG_DRV)
                                      | cw_bit(C_IMM_LD);
    localparam cword_t K_REG_TO_ADDR  = cw_bit(C_ADDR_LD) | cw_bit(C_REGB_EN)
                                      | cw_bit(C_REGB_DRV) | cw_bit(C_XBUS);
    localparam cword_t K_ALU_READ     = cw_bit(C_REGA_ALU) | cw_bit(C_REGB_EN)
                                      | cw_bit(C_REGB_ALU) | cw_bit(C_SRC_IMM)
                                      | cw_bit(C_DST_SEL);
    localparam cword_t K_MEM_TO_REG   = cw_bit(C_ADDR_DRV) | cw_bit(C_MEM_RD)
                                      | cw_bit(C_DST_SEL) | cw_bit(C_REG_WR)
                                      | cw_bit(C_END);
    localparam cword_t K_REG_TO_MEM   = cw_bit(C_DST_SEL) | cw_bit(C_REGA_DRV)
                                      | cw_bit(C_ADDR_DRV) | cw_bit(C_MEM_WR)
                                      | cw_bit(C_END);
    localparam cword_t K_EMPTY_STEP   = cw_bit(C_IDLE) | cw_bit(C_END);

endpackage

// File: rtl/ctrl_step_decode.sv
module ctrl_step_decode
    import ctrl_seq_pkg::*;
#(
    parameter int OPC_W = 6
) (
    input  logic [OPC_W-1:0] opc_i,
    input  logic             second_i,
    input  logic             zero_i,
    output cword_t           word_o
);

    cword_t first_w;
    cword_t second_w;

    // first execute step
    always_comb begin
        case (int'(opc_i))
            OP_HALT:   first_w = cw_bit(C_STOP);
            OP_LD_MEM,
            OP_PORT,
            OP_ST_MEM,
            OP_JUMP,
            OP_JZ:     first_w = K_WORD_TO_ADDR;
            OP_LD_IMM: first_w = K_WORD_TO_IMM;
            OP_ADD,
            OP_SUB,
            OP_MUL,
            OP_DIV:    first_w = K_ALU_READ | cw_bit(C_ALU_DRV)
                               | cw_bit(C_REG_WR) | cw_bit(C_END);
            OP_REM:    first_w = K_ALU_READ | cw_bit(C_ALU_DRV)
                               | cw_bit(C_REG_WR) | cw_bit(C_REM_SEL)
                               | cw_bit(C_END);
            OP_CMP:    first_w = K_ALU_READ | cw_bit(C_FLAG_LD) | cw_bit(C_END);
            OP_ST_IND,
            OP_LD_IND: first_w = K_REG_TO_ADDR;
            OP_MOVE:   first_w = cw_bit(C_REG_COPY) | cw_bit(C_SRC_IMM)
                               | cw_bit(C_REGB_EN) | cw_bit(C_REGB_DRV)
                               | cw_bit(C_DST_SEL) | cw_bit(C_REG_WR)
                               | cw_bit(C_END);
            default:   first_w = K_EMPTY_STEP;
        endcase
    end

    // second execute step
    always_comb begin
        case (int'(opc_i))
            OP_LD_MEM,
            OP_LD_IND: second_w = K_MEM_TO_REG;
            OP_PORT:   second_w = cw_bit(C_ADDR_DRV) | cw_bit(C_MEM_RD)
                                | cw_bit(C_PORT_LD) | cw_bit(C_END);
            OP_ST_MEM,
            OP_ST_IND: second_w = K_REG_TO_MEM;
            OP_LD_IMM: second_w = cw_bit(C_IMM_DRV) | cw_bit(C_DST_SEL)
                                | cw_bit(C_REG_WR) | cw_bit(C_END);
            OP_JUMP:   second_w = cw_bit(C_ADDR_DRV) | cw_bit(C_BRANCH)
                                | cw_bit(C_END);
            OP_JZ:     second_w = cw_bit(C_ADDR_DRV) | cw_bit(C_END)
                                | (zero_i ? cw_bit(C_BRANCH_Z) : cw_bit(C_IDLE));
            default:   second_w = K_EMPTY_STEP;
        endcase
    end

    assign word_o = second_i ? second_w : first_w;

endmodule

// File: rtl/ctrl_seq_fsm.sv
module ctrl_seq_fsm
    import ctrl_seq_pkg::*;
#(
    parameter int OPC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opc_i,
    input  logic             stop_i,
    input  logic             end_i,
    output tstate_e          state_o,
    output logic [OPC_W-1:0] opc_q_o
);

    tstate_e state_q;
    tstate_e state_d;
    logic [OPC_W-1:0] opc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            opc_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FETCH) begin
                opc_q <= opc_i;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: state_d = ST_EXEC1;
            ST_EXEC1: begin
                if (stop_i)     state_d = ST_HALT;
                else if (end_i) state_d = ST_FETCH;
                else            state_d = ST_EXEC2;
            end
            ST_EXEC2:  state_d = ST_FETCH;
            ST_HALT:   state_d = ST_HALT;
            default:   state_d = ST_FETCH;
        endcase
    end

    assign state_o = state_q;
    assign opc_q_o = opc_q;

    p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FETCH |=> state_q == ST_DECODE);
    p_decode_then_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DECODE |=> state_q == ST_EXEC1);
    p_exec2_to_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_EXEC2 |=> state_q == ST_FETCH);
    p_halt_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HALT |=> state_q == ST_HALT && $stable(opc_q));

endmodule

// File: rtl/ctrl_seq.sv
module ctrl_seq
    import ctrl_seq_pkg::*;
#(
    parameter int OPC_W = 6,
    parameter int TS_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opc_i,
    input  logic             zero_i,
    output logic [CW_W-1:0]  ctrl_o,
    output logic [TS_W-1:0]  tstate_o,
    output logic             ir_load_o,
    output logic             pc_inc_o
);

    tstate_e          state;
    logic [OPC_W-1:0] opc_q;
    cword_t           step_word;

    ctrl_seq_fsm #(.OPC_W(OPC_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .opc_i   (opc_i),
        .stop_i  (step_word[C_STOP]),
        .end_i   (step_word[C_END]),
        .state_o (state),
        .opc_q_o (opc_q)
    );

    ctrl_step_decode #(.OPC_W(OPC_W)) u_dec (
        .opc_i    (opc_q),
        .second_i (state == ST_EXEC2),
        .zero_i   (zero_i),
        .word_o   (step_word)
    );

    always_comb begin
        ctrl_o    = '0;
        ir_load_o = 1'b0;
        pc_inc_o  = 1'b0;
        unique case (state)
            ST_FETCH: begin
                ir_load_o = 1'b1;
                pc_inc_o  = 1'b1;
            end
            ST_DECODE: ctrl_o = '0;
            ST_EXEC1,
            ST_EXEC2:  ctrl_o = step_word;
            ST_HALT:   ctrl_o = cw_bit(C_STOP);
            default:   ctrl_o = '0;
        endcase
    end

    assign tstate_o = TS_W'(state);

    p_end_returns_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o[C_END] && (state == ST_EXEC1 || state == ST_EXEC2)) |=> state == ST_FETCH);
    p_exec2_has_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_EXEC2 |-> ctrl_o[C_END]);
    p_stop_enters_halt_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o[C_STOP] && state == ST_EXEC1) |=> tstate_o == TS_W'(ST_HALT));
    p_branch_needs_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[C_BRANCH_Z] |-> zero_i);
    p_cmp_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[C_FLAG_LD] |-> !ctrl_o[C_REG_WR] && !ctrl_o[C_ALU_DRV]);
    p_strobes_fetch_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_load_o || pc_inc_o) |-> ctrl_o == '0);

endmodule

// File: tb/sim_ctrl_seq.sv
`timescale 1ns/1ps
module sim_ctrl_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  opc = '0;
    logic        zero = 1'b0;
    logic [27:0] ctrl;
    logic [2:0]  ts;
    logic        irl;
    logic        pci;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    ctrl_seq u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .opc_i     (opc),
        .zero_i    (zero),
        .ctrl_o    (ctrl),
        .tstate_o  (ts),
        .ir_load_o (irl),
        .pc_inc_o  (pci)
    );

    function automatic logic [27:0] b(input int n);
        logic [27:0] w;
        w = '0;
        w[n] = 1'b1;
        return w;
    endfunction

    typedef struct {
        logic [2:0]  ts;
        logic [27:0] cw;
        logic        irl;
        logic        pci;
        string       tag;
    } item_t;

    item_t exp_q[$];

    task automatic push(input logic [2:0] t, input logic [27:0] w,
                        input logic l, input logic p, input string tag);
        item_t it;
        it.ts = t; it.cw = w; it.irl = l; it.pci = p; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic step_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // driver: called just after a rising edge at the start of a fetch cycle
    task automatic run_instr(input int op, input logic z, input logic [27:0] e1,
                             input logic two, input logic [27:0] e2, input string tag);
        opc  = 6'(op);
        zero = z;
        push(3'd0, 28'h0, 1'b1, 1'b1, "R1/R2 fetch");
        push(3'd1, 28'h0, 1'b0, 1'b0, "R2 decode");
        push(3'd2, e1, 1'b0, 1'b0, tag);
        if (two) push(3'd3, e2, 1'b0, 1'b0, tag);
        step_cycles(two ? 4 : 3);
        // R3: next fetch follows the end bit
        push(3'd0, 28'h0, 1'b1, 1'b1, "R3 back to fetch");
    endtask

    task automatic check_reset_now();
        @(negedge clk);
        checks++;
        if (ts !== 3'd0 || ctrl !== 28'h0 || irl !== 1'b1 || pci !== 1'b1) begin
            fails++;
            $display("FAIL R1 reset: got ts=%0d cw=%h irl=%b pci=%b, expected ts=0 cw=0 irl=1 pci=1",
                     ts, ctrl, irl, pci);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            checks++;
            if (ts !== it.ts || ctrl !== it.cw || irl !== it.irl || pci !== it.pci) begin
                fails++;
                $display("FAIL %s: got ts=%0d cw=%h irl=%b pci=%b, expected ts=%0d cw=%h irl=%b pci=%b",
                         it.tag, ts, ctrl, irl, pci, it.ts, it.cw, it.irl, it.pci);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    logic [27:0] to_addr, to_imm, alu_rd, ld2, st2, reg_addr, empty_w, halt_w;

    initial begin
        to_addr  = b(26) | b(25) | b(22) | b(17);
        to_imm   = b(26) | b(25) | b(24);
        alu_rd   = b(20) | b(19) | b(18) | b(16) | b(10);
        ld2      = b(10) | b(9) | b(4) | b(3) | b(0);
        st2      = b(10) | b(9) | b(8) | b(7) | b(0);
        reg_addr = b(23) | b(22) | b(18) | b(17);
        empty_w  = b(1) | b(0);
        halt_w   = b(2);

        // R1 reset state
        repeat (3) @(posedge clk);
        check_reset_now();
        @(posedge clk); #1;
        rst_n = 1'b1;

        run_instr(2, 1'b0, to_addr, 1'b1, ld2, "R4/R5 load direct");
        exp_q.delete(exp_q.size() - 1);
        run_instr(3, 1'b0, to_addr, 1'b1, b(9) | b(6) | b(3) | b(0), "R4/R5 port out");
        exp_q.delete(exp_q.size() - 1);
        run_instr(4, 1'b1, to_addr, 1'b1, st2, "R4/R5 store direct");
        exp_q.delete(exp_q.size() - 1);
        run_instr(6, 1'b0, to_addr, 1'b1, b(11) | b(9) | b(0), "R4/R5 jump");
        exp_q.delete(exp_q.size() - 1);
        run_instr(5, 1'b0, to_imm, 1'b1, b(10) | b(5) | b(4) | b(0), "R6 load immediate");
        exp_q.delete(exp_q.size() - 1);
        for (int op = 7; op <= 10; op++) begin
            run_instr(op, 1'b0, alu_rd | b(13) | b(4) | b(0), 1'b0, 28'h0, "R7 alu op");
            exp_q.delete(exp_q.size() - 1);
        end
        run_instr(11, 1'b0, alu_rd | b(13) | b(4) | b(0) | b(21), 1'b0, 28'h0, "R7 remainder");
        exp_q.delete(exp_q.size() - 1);
        run_instr(12, 1'b1, alu_rd | b(12) | b(0), 1'b0, 28'h0, "R8 compare");
        exp_q.delete(exp_q.size() - 1);
        run_instr(13, 1'b1, to_addr, 1'b1, b(9) | b(0) | b(15), "R9 jz taken");
        exp_q.delete(exp_q.size() - 1);
        run_instr(13, 1'b0, to_addr, 1'b1, b(9) | b(0) | b(1), "R9 jz not taken");
        exp_q.delete(exp_q.size() - 1);
        run_instr(14, 1'b0, reg_addr, 1'b1, st2, "R10 store indirect");
        exp_q.delete(exp_q.size() - 1);
        run_instr(15, 1'b0, reg_addr, 1'b1, ld2, "R10 load indirect");
        exp_q.delete(exp_q.size() - 1);
        run_instr(16, 1'b0, b(23) | b(18) | b(16) | b(14) | b(10) | b(4) | b(0),
                  1'b0, 28'h0, "R10 register move");
        exp_q.delete(exp_q.size() - 1);
        run_instr(0, 1'b1, empty_w, 1'b0, 28'h0, "R11 reserved opcode");
        exp_q.delete(exp_q.size() - 1);
        run_instr(17, 1'b0, empty_w, 1'b0, 28'h0, "R11 undefined 17");
        exp_q.delete(exp_q.size() - 1);
        run_instr(63, 1'b0, empty_w, 1'b0, 28'h0, "R11 undefined 63");
        exp_q.delete(exp_q.size() - 1);

        // R12 halt, then inputs toggled while halted
        opc = 6'd1;
        push(3'd0, 28'h0, 1'b1, 1'b1, "R2 fetch hlt");
        push(3'd1, 28'h0, 1'b0, 1'b0, "R2 decode hlt");
        push(3'd2, halt_w, 1'b0, 1'b0, "R12 hlt step");
        for (int i = 0; i < 6; i++) push(3'd4, halt_w, 1'b0, 1'b0, "R12 halted");
        step_cycles(3);
        for (int i = 0; i < 6; i++) begin
            opc  = 6'(7 + i);
            zero = i[0];
            step_cycles(1);
        end

        // R1 reset leaves halt
        rst_n = 1'b0;
        check_reset_now();
        @(posedge clk); #1;
        rst_n = 1'b1;
        run_instr(7, 1'b0, alu_rd | b(13) | b(4) | b(0), 1'b0, 28'h0, "R1/R7 after reset");
        step_cycles(1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule